// File: doc/BRIEF.md
# Pipeline Exception Arbiter and Redirect Control

This block runs exception control for a five-stage in-order pipeline. Fault detectors in three stages report to it: an undecodable instruction from decode, arithmetic overflow and a bad branch target from execute, and a bad data address from memory access. In each cycle it picks the oldest valid fault. It turns the faulting instruction and everything younger into no-ops, and it redirects instruction fetch to a handler. When the fault is taken, it captures a cause code and the faulting PC.

Two variants are chosen by a parameter. In the direct variant, the redirect goes out in the same cycle as the detection. Its target is a fixed handler address, or a separate fixed address for undecodable instructions. In the table variant, the block reads a handler pointer from a vector table in memory through a simple request/response port. It holds fetch until the pointer arrives and then redirects to it. Faults can nest: if the first handler word cannot be decoded, the block takes that fault the same way as any other.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, `cause_q` and `epc_q` are zero, and `kill`, `redir_vld`, `rd_req` and `pc_hold` are low.
- R2: A detector flag whose stage valid bit is low has no effect. No kill, no redirect and no read request follow from it, and `cause_q` and `epc_q` keep their values.
- R3: When several valid faults are reported in one cycle, the deepest stage wins: memory access, then execute, then decode. Within execute, overflow wins over a bad branch target.
- R4: In a detection cycle, `kill` covers the faulting stage and every younger stage. Bit 0 is fetch, bit 1 decode, bit 2 execute and bit 3 memory access. A fault in memory access gives 4'hF, in execute 4'h7, and in decode 4'h3.
- R5: In the direct variant, `redir_vld` is high in the detection cycle itself. `redir_pc` is `ILL_VEC` for an undecodable instruction and `FIX_VEC` for every other cause.
- R6: At the clock edge that ends a detection cycle, `cause_q` takes the code of the winning fault and `epc_q` takes its PC. The codes are: undecodable instruction 1, overflow 2, bad branch target 3, bad data address 4.
- R7: In the table variant, a detection cycle raises `rd_req` with `rd_addr = TBL_BASE + 4*code`. No redirect is issued in that cycle.
- R8: In the table variant, the block waits after a detection. While it waits, `pc_hold` is high, `kill` is 4'h1, and new detector reports are ignored. When `rd_rsp_vld` arrives, `redir_vld` rises with `redir_pc = rd_rsp_data` and the wait ends.
- R9: A valid undecodable-instruction report in decode, arriving right after a redirect, is taken as a new fault. `cause_q` becomes 1, `epc_q` becomes that handler PC, and fetch is redirected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_vld | input | 1 | Decode slot holds a real instruction |
| id_ill | input | 1 | Decode found an undecodable instruction |
| id_pc | input | AW | PC of the decode slot |
| ex_vld | input | 1 | Execute slot holds a real instruction |
| ex_ovf | input | 1 | Arithmetic overflow in execute |
| ex_bad_tgt | input | 1 | Bad branch target in execute |
| ex_pc | input | AW | PC of the execute slot |
| mem_vld | input | 1 | Memory-access slot holds a real instruction |
| mem_bad_addr | input | 1 | Bad data address in memory access |
| mem_pc | input | AW | PC of the memory-access slot |
| kill | output | 4 | Per-stage no-op mask (bit 0 fetch .. bit 3 memory access) |
| pc_hold | output | 1 | Freeze the PC while a table lookup is pending |
| redir_vld | output | 1 | Load `redir_pc` into the PC at the end of this cycle |
| redir_pc | output | AW | Redirect target |
| rd_req | output | 1 | Vector table read request |
| rd_addr | output | AW | Vector table read address |
| rd_rsp_vld | input | 1 | Vector table read data valid |
| rd_rsp_data | input | AW | Handler pointer read from the table |
| cause_q | output | 3 | Captured cause code |
| epc_q | output | AW | Captured faulting PC |

## Verification
The bench builds two copies of the block side by side, each with 32-bit PCs. One uses the direct variant with `FIX_VEC` = 32'hFFFF_F000 and `ILL_VEC` = 32'h0000_0010. The other uses the table variant with `TBL_BASE` = 32'h0000_2000. With these distinct, wide handler addresses, the direct copy shows a wrong-vector choice for a nested undecodable fault, and the table copy shows a wrong code-to-offset scaling. The table copy also brings within reach the pending-lookup window, in which fresh faults must be ignored, and the response-driven redirect.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int CAUSE_W = 3;
   localparam int N_SLOT  = 4;

   typedef enum logic [CAUSE_W-1:0] {
      EXC_NONE  = 3'd0,
      EXC_ILL   = 3'd1,
      EXC_OVF   = 3'd2,
      EXC_TGT   = 3'd3,
      EXC_DADDR = 3'd4
   } exc_code_e;

   localparam int SLOT_IF  = 0;
   localparam int SLOT_ID  = 1;
   localparam int SLOT_EX  = 2;
   localparam int SLOT_MEM = 3;
endpackage

// File: rtl/exc_prio.sv
module exc_prio
   import exc_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic              id_vld,
   input  logic              id_ill,
   input  logic [AW-1:0]     id_pc,
   input  logic              ex_vld,
   input  logic              ex_ovf,
   input  logic              ex_bad_tgt,
   input  logic [AW-1:0]     ex_pc,
   input  logic              mem_vld,
   input  logic              mem_bad_addr,
   input  logic [AW-1:0]     mem_pc,
   output logic              hit_o,
   output exc_code_e         code_o,
   output logic [AW-1:0]     pc_o,
   output logic [N_SLOT-1:0] mask_o
);
   localparam int SW = $clog2(N_SLOT);

   logic [SW-1:0] slot;

   // later assignments override earlier ones: deeper stage wins
   always_comb begin
      hit_o  = 1'b0;
      code_o = EXC_NONE;
      pc_o   = '0;
      slot   = '0;
      if (id_vld && id_ill) begin
         hit_o  = 1'b1;
         code_o = EXC_ILL;
         pc_o   = id_pc;
         slot   = SW'(SLOT_ID);
      end
      if (ex_vld && ex_bad_tgt) begin
         hit_o  = 1'b1;
         code_o = EXC_TGT;
         pc_o   = ex_pc;
         slot   = SW'(SLOT_EX);
      end
      if (ex_vld && ex_ovf) begin
         hit_o  = 1'b1;
         code_o = EXC_OVF;
         pc_o   = ex_pc;
         slot   = SW'(SLOT_EX);
      end
      if (mem_vld && mem_bad_addr) begin
         hit_o  = 1'b1;
         code_o = EXC_DADDR;
         pc_o   = mem_pc;
         slot   = SW'(SLOT_MEM);
      end
   end

   for (genvar g = 0; g < N_SLOT; g++) begin : g_mask
      assign mask_o[g] = hit_o && (SW'(g) <= slot);
   end
endmodule

// File: rtl/exc_capture.sv
module exc_capture
   import exc_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  exc_code_e          code_i,
   input  logic [AW-1:0]      pc_i,
   output logic [CAUSE_W-1:0] cause_q,
   output logic [AW-1:0]      epc_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= '0;
         epc_q   <= '0;
      end else if (load_i) begin
         cause_q <= code_i;
         epc_q   <= pc_i;
      end
   end
endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
   import exc_pkg::*;
#(
   parameter int          AW       = 32,
   parameter bit          VECTORED = 1'b0,
   parameter logic [AW-1:0] FIX_VEC  = '0,
   parameter logic [AW-1:0] ILL_VEC  = '0,
   parameter logic [AW-1:0] TBL_BASE = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          det_i,
   input  exc_code_e     code_i,
   input  logic          rsp_vld_i,
   input  logic [AW-1:0] rsp_data_i,
   output logic          busy_o,
   output logic          redir_vld_o,
   output logic [AW-1:0] redir_pc_o,
   output logic          rd_req_o,
   output logic [AW-1:0] rd_addr_o
);
   if (VECTORED) begin : g_table
      logic wait_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         wait_q <= 1'b0;
         else if (det_i)     wait_q <= 1'b1;
         else if (rsp_vld_i) wait_q <= 1'b0;
      end

      assign busy_o      = wait_q;
      assign rd_req_o    = det_i;
      assign rd_addr_o   = TBL_BASE + (AW'(code_i) << 2);
      assign redir_vld_o = wait_q && rsp_vld_i;
      assign redir_pc_o  = rsp_data_i;
   end else begin : g_direct
      logic unused_rsp;
      assign unused_rsp  = ^{clk, rst_n, rsp_vld_i, rsp_data_i};
      assign busy_o      = 1'b0;
      assign rd_req_o    = 1'b0;
      assign rd_addr_o   = '0;
      assign redir_vld_o = det_i;
      assign redir_pc_o  = (code_i == EXC_ILL) ? ILL_VEC : FIX_VEC;
   end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
   import exc_pkg::*;
#(
   parameter int            AW       = 32,
   parameter bit            VECTORED = 1'b0,
   parameter logic [AW-1:0] FIX_VEC  = 32'hFFFF_F000,
   parameter logic [AW-1:0] ILL_VEC  = 32'h0000_0010,
   parameter logic [AW-1:0] TBL_BASE = 32'h0000_2000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               id_vld,
   input  logic               id_ill,
   input  logic [AW-1:0]      id_pc,
   input  logic               ex_vld,
   input  logic               ex_ovf,
   input  logic               ex_bad_tgt,
   input  logic [AW-1:0]      ex_pc,
   input  logic               mem_vld,
   input  logic               mem_bad_addr,
   input  logic [AW-1:0]      mem_pc,
   output logic [3:0]         kill,
   output logic               pc_hold,
   output logic               redir_vld,
   output logic [AW-1:0]      redir_pc,
   output logic               rd_req,
   output logic [AW-1:0]      rd_addr,
   input  logic               rd_rsp_vld,
   input  logic [AW-1:0]      rd_rsp_data,
   output logic [2:0]         cause_q,
   output logic [AW-1:0]      epc_q
);
   if (AW < 8) begin : g_aw_chk
      $error("exc_ctrl: AW must be at least 8");
   end
   if (FIX_VEC[1:0] != 2'b00 || ILL_VEC[1:0] != 2'b00 || TBL_BASE[1:0] != 2'b00) begin : g_align_chk
      $error("exc_ctrl: vector addresses must be word aligned");
   end

   logic              hit;
   logic              det;
   logic              busy;
   exc_code_e         code;
   logic [AW-1:0]     fpc;
   logic [N_SLOT-1:0] mask;

   exc_prio #(.AW(AW)) u_prio (
      .id_vld       (id_vld),
      .id_ill       (id_ill),
      .id_pc        (id_pc),
      .ex_vld       (ex_vld),
      .ex_ovf       (ex_ovf),
      .ex_bad_tgt   (ex_bad_tgt),
      .ex_pc        (ex_pc),
      .mem_vld      (mem_vld),
      .mem_bad_addr (mem_bad_addr),
      .mem_pc       (mem_pc),
      .hit_o        (hit),
      .code_o       (code),
      .pc_o         (fpc),
      .mask_o       (mask)
   );

   assign det = hit && !busy;

   exc_capture #(.AW(AW)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (det),
      .code_i  (code),
      .pc_i    (fpc),
      .cause_q (cause_q),
      .epc_q   (epc_q)
   );

   exc_redirect #(
      .AW       (AW),
      .VECTORED (VECTORED),
      .FIX_VEC  (FIX_VEC),
      .ILL_VEC  (ILL_VEC),
      .TBL_BASE (TBL_BASE)
   ) u_redir (
      .clk         (clk),
      .rst_n       (rst_n),
      .det_i       (det),
      .code_i      (code),
      .rsp_vld_i   (rd_rsp_vld),
      .rsp_data_i  (rd_rsp_data),
      .busy_o      (busy),
      .redir_vld_o (redir_vld),
      .redir_pc_o  (redir_pc),
      .rd_req_o    (rd_req),
      .rd_addr_o   (rd_addr)
   );

   assign pc_hold = busy;
   assign kill    = busy ? 4'b0001 : (det ? mask : 4'b0000);
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          id_vld,
   input logic          id_ill,
   input logic          ex_vld,
   input logic          ex_ovf,
   input logic          ex_bad_tgt,
   input logic          mem_vld,
   input logic          mem_bad_addr,
   input logic [3:0]    kill,
   input logic          pc_hold,
   input logic          redir_vld,
   input logic          rd_req,
   input logic [2:0]    cause_q,
   input logic [AW-1:0] epc_q
);
   logic any_fault;
   assign any_fault = (id_vld && id_ill) || (ex_vld && (ex_ovf || ex_bad_tgt))
                      || (mem_vld && mem_bad_addr);

   // R4
   mem_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_hold && mem_vld && mem_bad_addr) |-> (kill == 4'hF));

   // R2
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_hold && !any_fault) |-> (kill == 4'h0 && !redir_vld && !rd_req));

   // R2
   hold_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_hold || !any_fault) |=> ($stable(cause_q) && $stable(epc_q)));

   // R6
   daddr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_hold && mem_vld && mem_bad_addr) |=> (cause_q == 3'd4));

   // R8
   hold_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_hold |-> (kill == 4'h1 && !rd_req));

   // R7
   req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && redir_vld));
endmodule

bind exc_ctrl exc_ctrl_chk #(.AW(AW)) u_exc_ctrl_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .id_vld       (id_vld),
   .id_ill       (id_ill),
   .ex_vld       (ex_vld),
   .ex_ovf       (ex_ovf),
   .ex_bad_tgt   (ex_bad_tgt),
   .mem_vld      (mem_vld),
   .mem_bad_addr (mem_bad_addr),
   .kill         (kill),
   .pc_hold      (pc_hold),
   .redir_vld    (redir_vld),
   .rd_req       (rd_req),
   .cause_q      (cause_q),
   .epc_q        (epc_q)
);

// File: tb/test_exc_ctrl.sv
module test_exc_ctrl;
   localparam int          AW  = 32;
   localparam logic [31:0] FIX = 32'hFFFF_F000;
   localparam logic [31:0] ILL = 32'h0000_0010;
   localparam logic [31:0] TBL = 32'h0000_2000;
   localparam logic [31:0] PC_ID  = 32'h0000_0100;
   localparam logic [31:0] PC_EX  = 32'h0000_00FC;
   localparam logic [31:0] PC_MEM = 32'h0000_00F8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          id_vld = 0, id_ill = 0, ex_vld = 0, ex_ovf = 0, ex_bad_tgt = 0;
   logic          mem_vld = 0, mem_bad_addr = 0;
   logic [AW-1:0] id_pc = PC_ID, ex_pc = PC_EX, mem_pc = PC_MEM;

   logic [3:0]    d_kill;
   logic          d_hold, d_rv, d_rq;
   logic [AW-1:0] d_rpc, d_ra, d_epc;
   logic [2:0]    d_cause;

   logic [3:0]    v_kill;
   logic          v_hold, v_rv, v_rq;
   logic [AW-1:0] v_rpc, v_ra, v_epc;
   logic [2:0]    v_cause;
   logic          v_rsp_vld = 1'b1;
   logic [AW-1:0] v_rsp_data = 32'h0000_4000;

   exc_ctrl #(.AW(AW), .VECTORED(1'b0), .FIX_VEC(FIX), .ILL_VEC(ILL), .TBL_BASE(TBL)) i_exc_ctrl (
      .clk(clk), .rst_n(rst_n),
      .id_vld(id_vld), .id_ill(id_ill), .id_pc(id_pc),
      .ex_vld(ex_vld), .ex_ovf(ex_ovf), .ex_bad_tgt(ex_bad_tgt), .ex_pc(ex_pc),
      .mem_vld(mem_vld), .mem_bad_addr(mem_bad_addr), .mem_pc(mem_pc),
      .kill(d_kill), .pc_hold(d_hold), .redir_vld(d_rv), .redir_pc(d_rpc),
      .rd_req(d_rq), .rd_addr(d_ra), .rd_rsp_vld(1'b0), .rd_rsp_data(32'h0),
      .cause_q(d_cause), .epc_q(d_epc)
   );

   exc_ctrl #(.AW(AW), .VECTORED(1'b1), .FIX_VEC(FIX), .ILL_VEC(ILL), .TBL_BASE(TBL)) i_exc_ctrl_vec (
      .clk(clk), .rst_n(rst_n),
      .id_vld(id_vld), .id_ill(id_ill), .id_pc(id_pc),
      .ex_vld(ex_vld), .ex_ovf(ex_ovf), .ex_bad_tgt(ex_bad_tgt), .ex_pc(ex_pc),
      .mem_vld(mem_vld), .mem_bad_addr(mem_bad_addr), .mem_pc(mem_pc),
      .kill(v_kill), .pc_hold(v_hold), .redir_vld(v_rv), .redir_pc(v_rpc),
      .rd_req(v_rq), .rd_addr(v_ra), .rd_rsp_vld(v_rsp_vld), .rd_rsp_data(v_rsp_data),
      .cause_q(v_cause), .epc_q(v_epc)
   );

   int total = 0;
   int bad = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic iv, input logic ii, input logic ev, input logic eo,
                        input logic et, input logic mv, input logic md);
      @(negedge clk);
      id_vld = iv; id_ill = ii; ex_vld = ev; ex_ovf = eo; ex_bad_tgt = et;
      mem_vld = mv; mem_bad_addr = md;
      #1;
   endtask

   task automatic idle_after_edge();
      @(posedge clk);
      #1;
      id_vld = 0; id_ill = 0; ex_vld = 0; ex_ovf = 0; ex_bad_tgt = 0;
      mem_vld = 0; mem_bad_addr = 0;
   endtask

   task automatic t_reset();
      check("R1 cause", 32'(d_cause), 0);
      check("R1 epc", d_epc, 0);
      check("R1 kill/redir/req/hold", {d_kill, d_rv, d_rq, d_hold}, 0);
      check("R1 vec req/hold", {v_kill, v_rq, v_hold}, 0);
   endtask

   task automatic t_single();
      drive(1, 1, 0, 0, 0, 0, 0);
      check("R4 id kill", 32'(d_kill), 32'h3);
      check("R5 id redir_vld", 32'(d_rv), 1);
      check("R5 ill vector", d_rpc, ILL);
      idle_after_edge();
      check("R6 id cause", 32'(d_cause), 1);
      check("R6 id epc", d_epc, PC_ID);

      drive(0, 0, 1, 0, 1, 0, 0);
      check("R4 ex kill", 32'(d_kill), 32'h7);
      check("R5 tgt vector", d_rpc, FIX);
      idle_after_edge();
      check("R6 tgt cause", 32'(d_cause), 3);
      check("R6 tgt epc", d_epc, PC_EX);

      drive(0, 0, 0, 0, 0, 1, 1);
      check("R4 mem kill", 32'(d_kill), 32'hF);
      check("R5 daddr vector", d_rpc, FIX);
      idle_after_edge();
      check("R6 daddr cause", 32'(d_cause), 4);
      check("R6 daddr epc", d_epc, PC_MEM);
   endtask

   task automatic t_bubble();
      drive(0, 1, 0, 1, 1, 0, 1);
      check("R2 bubble kill", 32'(d_kill), 0);
      check("R2 bubble redir", 32'(d_rv), 0);
      check("R2 bubble vec req", 32'(v_rq), 0);
      idle_after_edge();
      check("R2 bubble cause kept", 32'(d_cause), 4);
      check("R2 bubble epc kept", d_epc, PC_MEM);
   endtask

   task automatic t_priority();
      drive(1, 1, 1, 1, 1, 1, 1);
      check("R3 all kill", 32'(d_kill), 32'hF);
      idle_after_edge();
      check("R3 all cause", 32'(d_cause), 4);
      check("R3 all epc", d_epc, PC_MEM);

      drive(1, 1, 1, 1, 1, 0, 0);
      check("R3 ex over id kill", 32'(d_kill), 32'h7);
      check("R3 ex vector", d_rpc, FIX);
      idle_after_edge();
      check("R3 ovf over tgt cause", 32'(d_cause), 2);
      check("R3 ex epc", d_epc, PC_EX);
   endtask

   task automatic t_nested();
      drive(0, 0, 1, 1, 0, 0, 0);
      check("R9 first redirect", d_rpc, FIX);
      idle_after_edge();
      id_pc = FIX;
      drive(1, 1, 0, 0, 0, 0, 0);
      check("R9 nested redir_vld", 32'(d_rv), 1);
      check("R9 nested vector", d_rpc, ILL);
      check("R9 nested kill", 32'(d_kill), 32'h3);
      idle_after_edge();
      check("R9 nested cause", 32'(d_cause), 1);
      check("R9 nested epc", d_epc, FIX);
      id_pc = PC_ID;
   endtask

   task automatic t_vector();
      @(negedge clk);
      v_rsp_vld = 1'b0;
      v_rsp_data = 32'h0000_7A00;
      @(posedge clk);
      #1;
      check("R8 vec idle before", 32'(v_hold), 0);
      drive(0, 0, 1, 1, 0, 0, 0);
      check("R7 rd_req", 32'(v_rq), 1);
      check("R7 rd_addr", v_ra, TBL + 32'd8);
      check("R7 no redirect", 32'(v_rv), 0);
      check("R7 kill", 32'(v_kill), 32'h7);
      idle_after_edge();
      check("R6 vec cause", 32'(v_cause), 2);
      // new valid fault while waiting must be ignored
      drive(0, 0, 0, 0, 0, 1, 1);
      check("R8 hold", 32'(v_hold), 1);
      check("R8 wait kill", 32'(v_kill), 32'h1);
      check("R8 wait no req", 32'(v_rq), 0);
      check("R8 wait no redir", 32'(v_rv), 0);
      idle_after_edge();
      check("R8 cause not overwritten", 32'(v_cause), 2);
      check("R8 epc not overwritten", v_epc, PC_EX);
      @(negedge clk);
      v_rsp_vld = 1'b1;
      #1;
      check("R8 redirect on rsp", 32'(v_rv), 1);
      check("R8 redirect target", v_rpc, 32'h0000_7A00);
      @(posedge clk);
      #1;
      v_rsp_vld = 1'b0;
      check("R8 wait ends", 32'(v_hold), 0);
      // nested undecodable handler word in table variant
      id_pc = 32'h0000_7A00;
      drive(1, 1, 0, 0, 0, 0, 0);
      check("R9 vec nested req", 32'(v_rq), 1);
      check("R7 ill table slot", v_ra, TBL + 32'd4);
      idle_after_edge();
      check("R9 vec nested epc", v_epc, 32'h0000_7A00);
      id_pc = PC_ID;
   endtask

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            #1;
            t_reset();
            rst_n = 1'b1;
            repeat (2) @(posedge clk);
            #1;
            t_single();
            t_bubble();
            t_priority();
            t_nested();
            t_vector();
         end
         begin
            repeat (5000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      disable fork;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule